// File: doc/BRIEF.md
# Binary-Field Inversion Sequencer

This block finds the multiplicative inverse of an element of GF(2^M), M = 83 by default, using only a field multiplier that it shares with the rest of the datapath. By Fermat's theorem the inverse of a nonzero a is a^(2^M - 2), which is the square of a^(2^(M-1) - 1). The sequencer builds that power along an addition chain on the exponent length M-1, which it derives from the bits of M-1 when it is elaborated. Each bit below the leading one doubles the current length j: it issues j successive squarings, then one multiplication by the value saved before those squarings. A set bit then adds one more step: a squaring followed by a multiplication by a. One last squaring produces the inverse. For M = 83 the lengths run 1, 2, 4, 5, 10, 20, 40, 41, 82. That takes 82 squarings and 8 true multiplications, 90 multiplier calls in all.

The host pulses start with the operand present and then waits for a one-cycle done pulse. The result stays on its port until the next accepted start. A zero operand has no inverse. The block answers it at once with a zero result and a raised error flag, and it does not call the multiplier. The multiplier is outside the block. The sequencer presents two operands with a one-cycle request, then waits for the multiplier's completion strobe before it issues another request, so any multiplier latency works.

Top module: `gf2m_inv_seq`

## Requirements
- R1: After reset, busy, done, zero_err and mul_start are low and result is all zeros.
- R2: For a nonzero operand a, the run ends with a single-cycle done pulse and a result r such that a·r = 1 in GF(2^M) under the field polynomial of the attached multiplier.
- R3: A run on a nonzero operand issues exactly (M-1) + floor(log2(M-1)) + w(M-1) - 1 multiplier calls, where w is the number of set bits. For M = 83 that is 90 calls.
- R4: Each multiplier call raises mul_start for exactly one cycle. No new call is issued before mul_done returns, and mul_a and mul_b stay stable while a call is outstanding.
- R5: The result does not depend on the number of cycles the multiplier takes to raise mul_done.
- R6: A start with an all-zero operand gives done in the cycle after start, with result all zeros and zero_err high, and no multiplier call.
- R7: zero_err is low at the done of any run whose operand was nonzero, including a run that follows a zero-operand run.
- R8: A start pulse that arrives while busy is high is ignored. The run in progress finishes with the inverse of its own operand.
- R9: busy is high from the cycle after an accepted nonzero start until done. done rises in the cycle after the final mul_done, with busy already low. No call is issued while busy is low.
- R10: result holds its value after done until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to invert operand; sampled when idle |
| operand | input | M | Element to invert, polynomial basis |
| busy | output | 1 | Inversion in progress |
| done | output | 1 | One-cycle pulse: result valid |
| zero_err | output | 1 | Last operand was zero |
| result | output | M | Inverse of the last operand (zero for a zero operand) |
| mul_start | output | 1 | One-cycle request to the shared multiplier |
| mul_a | output | M | First multiplier operand |
| mul_b | output | M | Second multiplier operand |
| mul_done | input | 1 | Multiplier completion strobe, one cycle |
| mul_prod | input | M | Multiplier product, valid with mul_done |

## Verification
A zero operand gives done exactly one cycle after the start edge. The bench samples it at the next falling edge and does not poll for it. A nonzero run takes a variable time, because every call waits for mul_done. The bench therefore polls done at falling edges and, at that same sample, checks that busy is already low, that the result is correct and that the number of one-cycle requests it counted since start is right. It checks at the next falling edge that done has dropped, and some cycles later that result has held. The bench's multiplier model answers each request after a latency that the bench sets per test. The same operands are run at several latencies, so the result is shown not to depend on handshake timing.

// File: rtl/gf2m_inv_pkg.sv
package gf2m_inv_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } inv_state_e;

   // Kind of multiplier call currently in flight.
   typedef enum logic [2:0] {
      OP_NONE = 3'd0,
      OP_DSQ  = 3'd1,   // squaring inside a doubling step
      OP_DMUL = 3'd2,   // product with the saved power closing a doubling
      OP_OSQ  = 3'd3,   // squaring of the odd step
      OP_OMUL = 3'd4,   // product with the operand closing the odd step
      OP_FSQ  = 3'd5    // final squaring giving the inverse
   } inv_op_e;

   function automatic int f_msb(input int v);
      int r;
      r = 0;
      for (int i = 0; i < 31; i++)
         if (((v >> i) & 1) != 0) r = i;
      return r;
   endfunction

   function automatic int f_popcnt(input int v);
      int r;
      r = 0;
      for (int i = 0; i < 31; i++)
         if (((v >> i) & 1) != 0) r = r + 1;
      return r;
   endfunction

   // Squarings (m-1) plus chain products floor(log2(m-1)) + w(m-1) - 1.
   function automatic int f_total_calls(input int m);
      return (m - 1) + f_msb(m - 1) + f_popcnt(m - 1) - 1;
   endfunction

endpackage

// File: rtl/gf2m_inv_zdet.sv
module gf2m_inv_zdet #(
   parameter int M     = 83,
   parameter int CHUNK = 8
) (
   input  logic [M-1:0] value,
   output logic         is_zero
);
   localparam int NCH = (M + CHUNK - 1) / CHUNK;
   localparam int PW  = NCH * CHUNK;

   logic [PW-1:0]  padded;
   logic [NCH-1:0] any_set;

   assign padded = PW'(value);

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_chunk
         assign any_set[g] = |padded[g*CHUNK +: CHUNK];
      end
   endgenerate

   assign is_zero = ~|any_set;
endmodule

// File: rtl/gf2m_inv_ctl.sv
module gf2m_inv_ctl
   import gf2m_inv_pkg::*;
#(
   parameter int M = 83
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  logic    is_zero,
   input  logic    mul_done,
   output logic    busy,
   output logic    done,
   output logic    zero_err,
   output logic    mul_start,
   output inv_op_e op,
   output logic    ld_x,
   output logic    acc_we,
   output logic    save_we,
   output logic    res_we,
   output logic    res_clr
);
   localparam int E        = M - 1;
   localparam int EW       = $clog2(M);
   localparam int LW       = EW + 1;
   localparam int IW       = (EW > 1) ? $clog2(EW) : 1;
   localparam int TOP      = f_msb(E);
   localparam int BW       = 1 << IW;
   localparam logic [BW-1:0] EBITS    = BW'(E);
   localparam logic [IW-1:0] IDX_INIT = IW'(TOP - 1);

   inv_state_e    st_q, st_d;
   inv_op_e       op_q, op_d;
   logic [LW-1:0] len_q, len_d;
   logic [LW-1:0] cnt_q, cnt_d;
   logic [IW-1:0] idx_q, idx_d;
   logic          done_q, done_d;
   logic          err_q, err_d;
   logic          ebit;
   logic          adv;

   assign ebit = EBITS[idx_q];

   always_comb begin
      st_d    = st_q;
      op_d    = op_q;
      len_d   = len_q;
      cnt_d   = cnt_q;
      idx_d   = idx_q;
      done_d  = 1'b0;
      err_d   = err_q;
      ld_x    = 1'b0;
      acc_we  = 1'b0;
      save_we = 1'b0;
      res_we  = 1'b0;
      res_clr = 1'b0;
      adv     = 1'b0;
      unique case (st_q)
         ST_IDLE: begin
            if (start) begin
               if (is_zero) begin
                  done_d  = 1'b1;
                  err_d   = 1'b1;
                  res_clr = 1'b1;
               end else begin
                  st_d  = ST_ISSUE;
                  op_d  = OP_DSQ;
                  len_d = LW'(1);
                  cnt_d = LW'(1);
                  idx_d = IDX_INIT;
                  err_d = 1'b0;
                  ld_x  = 1'b1;
               end
            end
         end
         ST_ISSUE: st_d = ST_WAIT;
         ST_WAIT: begin
            if (mul_done) begin
               st_d   = ST_ISSUE;
               acc_we = (op_q != OP_FSQ);
               unique case (op_q)
                  OP_DSQ: begin
                     if (cnt_q == LW'(1)) op_d = OP_DMUL;
                     else                 cnt_d = cnt_q - LW'(1);
                  end
                  OP_DMUL: begin
                     len_d = len_q << 1;
                     if (ebit) op_d = OP_OSQ;
                     else      adv  = 1'b1;
                  end
                  OP_OSQ: op_d = OP_OMUL;
                  OP_OMUL: begin
                     len_d = len_q + LW'(1);
                     adv   = 1'b1;
                  end
                  default: begin
                     st_d   = ST_IDLE;
                     op_d   = OP_NONE;
                     res_we = 1'b1;
                     done_d = 1'b1;
                  end
               endcase
               if (adv) begin
                  if (idx_q == '0) begin
                     op_d = OP_FSQ;
                  end else begin
                     idx_d   = idx_q - IW'(1);
                     op_d    = OP_DSQ;
                     cnt_d   = len_d;
                     save_we = 1'b1;
                  end
               end
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         op_q   <= OP_NONE;
         len_q  <= '0;
         cnt_q  <= '0;
         idx_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         op_q   <= op_d;
         len_q  <= len_d;
         cnt_q  <= cnt_d;
         idx_q  <= idx_d;
         done_q <= done_d;
         err_q  <= err_d;
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign mul_start = (st_q == ST_ISSUE);
   assign done      = done_q;
   assign zero_err  = err_q;
   assign op        = op_q;
endmodule

// File: rtl/gf2m_inv_dp.sv
module gf2m_inv_dp
   import gf2m_inv_pkg::*;
#(
   parameter int M = 83
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [M-1:0] operand,
   input  inv_op_e      op,
   input  logic         ld_x,
   input  logic         acc_we,
   input  logic         save_we,
   input  logic         res_we,
   input  logic         res_clr,
   input  logic [M-1:0] mul_prod,
   output logic [M-1:0] mul_a,
   output logic [M-1:0] mul_b,
   output logic [M-1:0] result
);
   logic [M-1:0] x_q;     // operand of the run
   logic [M-1:0] acc_q;   // current power a^(2^j - 1), squared in place
   logic [M-1:0] save_q;  // power held at the start of a doubling
   logic [M-1:0] res_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q    <= '0;
         acc_q  <= '0;
         save_q <= '0;
         res_q  <= '0;
      end else begin
         if (ld_x) begin
            x_q    <= operand;
            acc_q  <= operand;
            save_q <= operand;
         end else begin
            if (acc_we)  acc_q  <= mul_prod;
            if (save_we) save_q <= mul_prod;
         end
         if (res_clr)     res_q <= '0;
         else if (res_we) res_q <= mul_prod;
      end
   end

   always_comb begin
      mul_a = acc_q;
      unique case (op)
         OP_DMUL: mul_b = save_q;
         OP_OMUL: mul_b = x_q;
         default: mul_b = acc_q;
      endcase
   end

   assign result = res_q;
endmodule

// File: rtl/gf2m_inv_seq.sv
module gf2m_inv_seq
   import gf2m_inv_pkg::*;
#(
   parameter int M      = 83,
   parameter int ZCHUNK = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [M-1:0] operand,
   output logic         busy,
   output logic         done,
   output logic         zero_err,
   output logic [M-1:0] result,
   output logic         mul_start,
   output logic [M-1:0] mul_a,
   output logic [M-1:0] mul_b,
   input  logic         mul_done,
   input  logic [M-1:0] mul_prod
);
   generate
      if (M < 3) begin : g_bad_m
         $error("gf2m_inv_seq: M must be at least 3");
      end
      if (ZCHUNK < 1) begin : g_bad_chunk
         $error("gf2m_inv_seq: ZCHUNK must be positive");
      end
   endgenerate

   logic    is_zero;
   inv_op_e op;
   logic    ld_x, acc_we, save_we, res_we, res_clr;

   gf2m_inv_zdet #(.M(M), .CHUNK(ZCHUNK)) u_zdet (
      .value   (operand),
      .is_zero (is_zero)
   );

   gf2m_inv_ctl #(.M(M)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .is_zero   (is_zero),
      .mul_done  (mul_done),
      .busy      (busy),
      .done      (done),
      .zero_err  (zero_err),
      .mul_start (mul_start),
      .op        (op),
      .ld_x      (ld_x),
      .acc_we    (acc_we),
      .save_we   (save_we),
      .res_we    (res_we),
      .res_clr   (res_clr)
   );

   gf2m_inv_dp #(.M(M)) u_dp (
      .clk      (clk),
      .rst_n    (rst_n),
      .operand  (operand),
      .op       (op),
      .ld_x     (ld_x),
      .acc_we   (acc_we),
      .save_we  (save_we),
      .res_we   (res_we),
      .res_clr  (res_clr),
      .mul_prod (mul_prod),
      .mul_a    (mul_a),
      .mul_b    (mul_b),
      .result   (result)
   );
endmodule

// File: rtl/gf2m_inv_chk.sv
module gf2m_inv_chk
   import gf2m_inv_pkg::*;
#(
   parameter int M = 83
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic         busy,
   input logic         done,
   input logic         zero_err,
   input logic [M-1:0] result,
   input logic         mul_start,
   input logic [M-1:0] mul_a,
   input logic [M-1:0] mul_b,
   input logic         mul_done
);
   localparam int TOTAL = f_total_calls(M);

   logic        out_q;
   logic [15:0] calls_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q   <= 1'b0;
         calls_q <= '0;
      end else begin
         if (mul_start)     out_q <= 1'b1;
         else if (mul_done) out_q <= 1'b0;
         if (start && !busy) calls_q <= '0;
         else if (mul_start) calls_q <= calls_q + 16'd1;
      end
   end

   p_call_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mul_start |=> !mul_start);

   p_one_outstanding_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> !mul_start);

   p_opnd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_q && !mul_done) |=> ($stable(mul_a) && $stable(mul_b)));

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mul_start);

   p_done_after_prod_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !zero_err) |-> $past(mul_done));

   p_call_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !zero_err) |-> (calls_q == 16'(TOTAL)));

   p_zero_nocall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && zero_err) |-> (calls_q == 16'd0 && result == '0));
endmodule

bind gf2m_inv_seq gf2m_inv_chk #(.M(M)) u_chk (.*);

// File: tb/test_gf2m_inv_seq.sv
module test_gf2m_inv_seq;
   localparam int M        = 83;
   localparam int CLK_PER  = 10;
   localparam int CALLS    = 90;
   localparam int WD_LIMIT = 150000;
   // Field polynomial x^83 + x^7 + x^4 + x^2 + 1, low terms only.
   localparam logic [M-1:0] POLY_LOW = (M'(1) << 7) | (M'(1) << 4) | (M'(1) << 2) | M'(1);

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [M-1:0] operand = '0;
   logic         busy, done, zero_err;
   logic [M-1:0] result;
   logic         mul_start;
   logic [M-1:0] mul_a, mul_b;
   logic         mul_done = 1'b0;
   logic [M-1:0] mul_prod = '0;

   int checks = 0;
   int fails  = 0;
   int calls  = 0;
   int lat    = 1;
   bit finished = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   gf2m_inv_seq #(.M(M)) i_gf2m_inv_seq (
      .clk (clk), .rst_n (rst_n), .start (start), .operand (operand),
      .busy (busy), .done (done), .zero_err (zero_err), .result (result),
      .mul_start (mul_start), .mul_a (mul_a), .mul_b (mul_b),
      .mul_done (mul_done), .mul_prod (mul_prod)
   );

   function automatic logic [M-1:0] gfmul(input logic [M-1:0] a, input logic [M-1:0] b);
      logic [M-1:0] r;
      r = '0;
      for (int i = M-1; i >= 0; i--) begin
         r = {r[M-2:0], 1'b0} ^ (r[M-1] ? POLY_LOW : '0);
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   // a^(2^M - 2): exponent bits M-1..1 set, bit 0 clear.
   function automatic logic [M-1:0] ginv(input logic [M-1:0] a);
      logic [M-1:0] r;
      r = M'(1);
      for (int i = M-1; i >= 0; i--) begin
         r = gfmul(r, r);
         if (i >= 1) r = gfmul(r, a);
      end
      return r;
   endfunction

   // Multiplier model, acting at falling edges.
   initial begin
      logic [M-1:0] ma, mb;
      int cd;
      cd = 0; ma = '0; mb = '0;
      forever begin
         @(negedge clk);
         mul_done = 1'b0;
         if (cd > 0) begin
            cd = cd - 1;
            if (cd == 0) begin
               mul_prod = gfmul(ma, mb);
               mul_done = 1'b1;
            end
         end else if (mul_start) begin
            ma = mul_a;
            mb = mul_b;
            cd = lat;
         end
      end
   end

   // Request counter.
   initial forever begin
      @(negedge clk);
      if (mul_start) calls = calls + 1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [M-1:0] act, input logic [M-1:0] exp);
      checks = checks + 1;
      if (!ok) begin
         fails = fails + 1;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input logic [M-1:0] a);
      @(negedge clk);
      operand = a;
      start   = 1'b1;
      @(negedge clk);
      start   = 1'b0;
   endtask

   task automatic wait_done(input string req, output bit seen);
      seen = 1'b0;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin seen = 1'b1; break; end
         @(negedge clk);
      end
      chk(seen, req, "done within limit", M'(seen), M'(1));
   endtask

   task automatic t_reset;
      chk(!busy && !done && !zero_err && !mul_start, "R1", "control outputs idle",
          M'({busy, done, zero_err, mul_start}), '0);
      chk(result == '0, "R1", "result cleared", result, '0);
   endtask

   task automatic t_invert(input logic [M-1:0] a, input int l, input string req);
      bit seen;
      logic [M-1:0] held;
      lat = l;
      calls = 0;
      pulse_start(a);
      chk(busy, "R9", "busy after start", M'(busy), M'(1));
      wait_done(req, seen);
      if (seen) begin
         chk(!busy, "R9", "busy low at done", M'(busy), '0);
         chk(!zero_err, "R7", "no error on nonzero operand", M'(zero_err), '0);
         chk(result == ginv(a), req, "inverse value", result, ginv(a));
         chk(gfmul(a, result) == M'(1), "R2", "a times result is one", gfmul(a, result), M'(1));
         chk(calls == CALLS, "R3", "multiplier call count", M'(calls), M'(CALLS));
         held = result;
         @(negedge clk);
         chk(!done, "R2", "done lasts one cycle", M'(done), '0);
         repeat (5) @(negedge clk);
         chk(result == held, "R10", "result held after done", result, held);
      end
   endtask

   task automatic t_zero;
      calls = 0;
      pulse_start('0);
      chk(done && zero_err, "R6", "done and error one cycle after start",
          M'({done, zero_err}), M'(3));
      chk(result == '0, "R6", "zero result", result, '0);
      chk(!busy, "R6", "not busy", M'(busy), '0);
      repeat (4) @(negedge clk);
      chk(calls == 0, "R6", "no multiplier call", M'(calls), '0);
   endtask

   task automatic t_busy_ignore(input logic [M-1:0] a, input logic [M-1:0] b);
      bit seen;
      lat = 2;
      calls = 0;
      pulse_start(a);
      repeat (20) @(negedge clk);
      operand = b;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done("R8", seen);
      if (seen) begin
         chk(result == ginv(a), "R8", "late start ignored", result, ginv(a));
         chk(calls == CALLS, "R8", "single run of calls", M'(calls), M'(CALLS));
         chk(!zero_err, "R8", "zero late operand ignored", M'(zero_err), '0);
      end
   endtask

   initial begin
      repeat (WD_LIMIT) @(posedge clk);
      if (!finished) begin
         checks = checks + 1;
         fails  = fails + 1;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();                                   // R1 before reset release
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();                                   // R1 after release
      t_invert(M'(1), 1, "R2");
      t_invert(M'(2), 1, "R2");
      t_invert(83'h5_1234_5678_9ABC_DEF0_1357, 1, "R2");
      t_invert(83'h7_FFFF_FFFF_FFFF_FFFF_FFFF, 3, "R5");
      t_invert(83'h5_1234_5678_9ABC_DEF0_1357, 7, "R5");
      t_invert(83'h4_0000_0000_0000_0000_0000, 4, "R5");
      t_zero();
      t_invert(83'h0_0000_0000_00A5_0000_0081, 2, "R7");
      t_busy_ignore(83'h2_DEAD_BEEF_0123_4567_89AB, '0);
      t_busy_ignore(83'h1_0F0F_0F0F_0F0F_0F0F_0F0F, 83'h3_3333);
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule